// File: doc/BRIEF.md
# Continue-Marker Run Expander

This block sits on the receive side of a serial storage link layer. The far end may shorten a long run of one primitive by sending that primitive once and then a continue marker, followed by filler. This block rebuilds the full run. While it is expanding, every position after the marker carries the last real primitive again. Data dwords and new primitives end or pass through the expansion according to the rules below.

The block takes one 32-bit dword per transfer together with a 4-bit control-character mask. A dword is a primitive when bit 0 of the mask is set. Both sides of the block use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. The output stage is one register deep, so `in_ready` is high whenever that register is empty or is being drained in the same cycle. The upstream side must hold `in_valid`, `in_data` and `in_ctrl` steady until the transfer is accepted. The block holds its output steady while `out_ready` is low.

The block also drives a plain pulse output, `hist_clear`. It tells the transmit side to forget its history of recently sent primitives when a HOLD arrives in the middle of an expanded run.

Top module: `cont_expander`

## Requirements
- R1: After synchronous active-high reset, `out_valid` and `hist_clear` are 0, `in_ready` is 1, repeat mode is off and the held primitive is SYNC (0xB5B5957C). A continue marker accepted first therefore outputs 0xB5B5957C.
- R2: An accepted continue marker (mask bit 0 set, data 0x9999AA7C) turns repeat mode on. Its own output position carries the held primitive with mask 4'b0001.
- R3: While repeat mode is on, an accepted data dword (mask bit 0 clear) is output as the held primitive with mask 4'b0001.
- R4: An accepted primitive other than the continue marker becomes the held primitive and turns repeat mode off. It is itself output unchanged, with its own mask.
- R5: An accepted data dword while repeat mode is off is output unchanged and does not alter the held primitive.
- R6: When HOLD (0xD5D5AA7C with mask bit 0 set) is accepted while repeat mode is on, `hist_clear` is high for exactly one cycle. That cycle is the first cycle in which the HOLD appears at the output. A HOLD accepted with repeat mode off gives no pulse.
- R7: Each accepted dword appears at the output on the clock edge after acceptance. While `out_valid` is high and `out_ready` is low, the output data and mask stay stable and `in_ready` is 0.
- R8: Cycles without an accepted input leave repeat mode and the held primitive unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input dword is offered |
| in_ready | output | 1 | Block can accept an input dword this cycle |
| in_data | input | 32 | Received dword |
| in_ctrl | input | 4 | Control-character mask per byte; bit 0 marks a primitive |
| out_valid | output | 1 | Output dword is offered |
| out_ready | input | 1 | Downstream accepts the output dword |
| out_data | output | 32 | Expanded dword |
| out_ctrl | output | 4 | Mask for the expanded dword |
| hist_clear | output | 1 | One-cycle pulse that clears the transmit-side repeat history |

## Verification
The hardest situation to reach is a HOLD that is accepted while repeat mode is on and the output register is stalled. In that case the pulse must line up with the HOLD actually reaching the output, and it must not be lost or repeated. Random stimulus gives continue markers and HOLDs high weights and drops `out_ready` about a quarter of the time, so this case comes up many times. Directed sequences also cover a HOLD accepted with repeat mode off and a continue marker accepted straight after reset.

// File: rtl/cont_exp_pkg.sv
package cont_exp_pkg;
  localparam int DW = 32;
  localparam int CW = 4;

  localparam logic [DW-1:0] PRIM_CONT = 32'h9999AA7C;
  localparam logic [DW-1:0] PRIM_HOLD = 32'hD5D5AA7C;
  localparam logic [DW-1:0] PRIM_SYNC = 32'hB5B5957C;
  localparam logic [CW-1:0] CTRL_PRIM = 4'b0001;

  typedef struct packed {
    logic is_prim;
    logic is_cont;
    logic is_hold;
  } dw_class_t;
endpackage

// File: rtl/cont_classify.sv
module cont_classify
  import cont_exp_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CTRL_W = CW
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CTRL_W-1:0] ctrl,
  output dw_class_t         cls
);
  always_comb begin
    cls.is_prim = ctrl[0];
    cls.is_cont = ctrl[0] && (data == PRIM_CONT);
    cls.is_hold = ctrl[0] && (data == PRIM_HOLD);
  end
endmodule

// File: rtl/cont_tracker.sv
module cont_tracker
  import cont_exp_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CTRL_W = CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  dw_class_t         cls,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic [DATA_W-1:0] sub_data,
  output logic [CTRL_W-1:0] sub_ctrl,
  output logic              clr_req
);
  logic              rep_mode;
  logic [DATA_W-1:0] last_prim;

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_mode  <= 1'b0;
      last_prim <= PRIM_SYNC;
    end else if (adv) begin
      if (cls.is_cont) begin
        rep_mode <= 1'b1;
      end else if (cls.is_prim) begin
        rep_mode  <= 1'b0;
        last_prim <= in_data;
      end
    end
  end

  always_comb begin
    sub_data = in_data;
    sub_ctrl = in_ctrl;
    if (cls.is_cont || (rep_mode && !cls.is_prim)) begin
      sub_data = last_prim;
      sub_ctrl = CTRL_PRIM;
    end
    clr_req = adv && cls.is_hold && rep_mode;
  end

  // R2
  assert_cont_enters_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && cls.is_cont) |=> rep_mode);
  // R4
  assert_prim_latched_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && cls.is_prim && !cls.is_cont) |=> (!rep_mode && last_prim == $past(in_data)));
  // R5
  assert_data_keeps_prim_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && !cls.is_prim) |=> $stable(last_prim));
  // R8
  assert_idle_keeps_state_R8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(rep_mode) && $stable(last_prim)));
endmodule

// File: rtl/cont_out_stage.sv
module cont_out_stage
  import cont_exp_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CTRL_W = CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_valid,
  output logic              i_ready,
  input  logic [DATA_W-1:0] i_data,
  input  logic [CTRL_W-1:0] i_ctrl,
  input  logic              i_clr,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DATA_W-1:0] o_data,
  output logic [CTRL_W-1:0] o_ctrl,
  output logic              o_clr
);
  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_clr   <= 1'b0;
      o_data  <= '0;
      o_ctrl  <= '0;
    end else begin
      o_clr <= i_clr;
      if (i_ready) begin
        o_valid <= i_valid;
        o_data  <= i_data;
        o_ctrl  <= i_ctrl;
      end
    end
  end

  // R7
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_ctrl)));
endmodule

// File: rtl/cont_expander.sv
module cont_expander
  import cont_exp_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CTRL_W = CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              hist_clear
);
  dw_class_t         cls;
  logic              adv;
  logic [DATA_W-1:0] sub_data;
  logic [CTRL_W-1:0] sub_ctrl;
  logic              clr_req;

  assign adv = in_valid && in_ready;

  cont_classify #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_classify (
    .data(in_data), .ctrl(in_ctrl), .cls(cls)
  );

  cont_tracker #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_tracker (
    .clk(clk), .rst(rst), .adv(adv), .cls(cls),
    .in_data(in_data), .in_ctrl(in_ctrl),
    .sub_data(sub_data), .sub_ctrl(sub_ctrl), .clr_req(clr_req)
  );

  cont_out_stage #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_out (
    .clk(clk), .rst(rst),
    .i_valid(in_valid), .i_ready(in_ready),
    .i_data(sub_data), .i_ctrl(sub_ctrl), .i_clr(clr_req),
    .o_valid(out_valid), .o_ready(out_ready),
    .o_data(out_data), .o_ctrl(out_ctrl), .o_clr(hist_clear)
  );

  // R6
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    hist_clear |=> !hist_clear);
  // R6
  assert_pulse_with_hold_R6: assert property (@(posedge clk) disable iff (rst)
    hist_clear |-> (out_valid && out_data == PRIM_HOLD && out_ctrl[0]));
endmodule

// File: tb/cont_expander_bench.sv
module cont_expander_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CONT = 32'h9999AA7C;
  localparam logic [31:0] HOLD = 32'hD5D5AA7C;
  localparam logic [31:0] SYNC = 32'hB5B5957C;
  localparam logic [31:0] XRDY = 32'h5757B57C;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, out_valid, out_ready, hist_clear;
  logic [31:0] in_data, out_data;
  logic [3:0] in_ctrl, out_ctrl;

  int total = 0;
  int bad = 0;
  int exp_pulses = 0;
  int obs_pulses = 0;
  bit finished = 0;

  logic        ref_rep;
  logic [31:0] ref_last;
  logic [35:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cont_expander u_cont_expander (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ctrl(out_ctrl),
    .hist_clear(hist_clear)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [35:0] model(input logic [31:0] d, input logic [3:0] c);
    logic [35:0] r;
    bit prim, cont;
    prim = c[0];
    cont = prim && d == CONT;
    r = {c, d};
    if (cont || (ref_rep && !prim)) r = {4'b0001, ref_last};
    if (prim && d == HOLD && ref_rep) exp_pulses++;
    if (cont) ref_rep = 1'b1;
    else if (prim) begin ref_rep = 1'b0; ref_last = d; end
    return r;
  endfunction

  task automatic step(input logic v, input logic [31:0] d, input logic [3:0] c,
                      input logic ordy, output bit acc);
    logic [35:0] e;
    @(negedge clk);
    if (hist_clear) begin
      obs_pulses++;
      chk(out_valid && out_data == HOLD, "R6 pulse not aligned with HOLD output",
          {31'b0, out_valid, out_data}, {32'h1, HOLD});
    end
    in_valid = v; in_data = d; in_ctrl = c; out_ready = ordy;
    #1;
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 output without accepted input", {28'b0, out_ctrl, out_data}, 64'h0);
      end else begin
        e = q.pop_front();
        // R1 R2 R3 R4 R5 checked through the reference model
        chk({out_ctrl, out_data} == e, "R1/R2/R3/R4/R5 output dword",
            {28'b0, out_ctrl, out_data}, {28'b0, e});
      end
    end
    acc = v && in_ready;
    if (acc) q.push_back(model(d, c));
  endtask

  task automatic send(input logic [31:0] d, input logic [3:0] c);
    bit acc;
    do step(1'b1, d, c, 1'b1, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 4'h0, 1'b1, acc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [31:0] d;
    logic [3:0] c;
    logic v, pend;
    logic [31:0] held_d;
    logic [3:0] held_c;
    void'($urandom(32'd4242));
    ref_rep = 1'b0; ref_last = SYNC;
    rst = 1'b1; in_valid = 0; in_data = 0; in_ctrl = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(!out_valid, "R1 out_valid after reset", {63'b0, out_valid}, 64'h0);
    chk(!hist_clear, "R1 hist_clear after reset", {63'b0, hist_clear}, 64'h0);
    chk(in_ready, "R1 in_ready after reset", {63'b0, in_ready}, 64'h1);

    // R1 R2: continue first outputs SYNC; R3 data replaced
    send(CONT, 4'b0001);
    send(32'h12345678, 4'b0000);
    // R6 HOLD in repeat gives a pulse
    send(HOLD, 4'b0001);
    // R5 data passes, R2 continue repeats HOLD
    send(32'hCAFE0001, 4'b0000);
    send(CONT, 4'b0001);
    send(32'h0BADF00D, 4'b0000);
    // R4 new primitive leaves repeat
    send(XRDY, 4'b0001);
    send(32'h11112222, 4'b0000);
    // R6 HOLD outside repeat: no pulse
    send(HOLD, 4'b0001);
    idle(3);
    // R8 idle keeps state: continue then gap then data
    send(CONT, 4'b0001);
    idle(4);
    send(32'h55667788, 4'b0000);
    idle(2);
    chk(obs_pulses == exp_pulses, "R6 directed pulse count", obs_pulses, exp_pulses);
    chk(exp_pulses == 1, "R6 directed expected pulses", exp_pulses, 1);

    // R7 stall: item held while out_ready low
    step(1'b1, XRDY, 4'b0001, 1'b1, acc);
    step(1'b0, 32'h0, 4'h0, 1'b0, acc);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 32'hDEAD0000, 4'b0000, 1'b0, acc);
      chk(!in_ready, "R7 in_ready low while stalled", {63'b0, in_ready}, 64'h0);
      chk(out_valid && out_data == XRDY, "R7 output stable while stalled",
          {31'b0, out_valid, out_data}, {32'h1, XRDY});
    end
    do step(1'b1, 32'hDEAD0000, 4'b0000, 1'b1, acc); while (!acc);
    idle(2);

    // random phase, R2 R3 R4 R5 R6 R7 R8
    pend = 0; held_d = 0; held_c = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!pend) begin
        int k;
        k = $urandom_range(0, 9);
        case (k)
          0, 1, 2: begin d = CONT; c = 4'b0001; end
          3, 4:    begin d = HOLD; c = 4'b0001; end
          5:       begin d = SYNC; c = 4'b0001; end
          6:       begin d = XRDY; c = 4'b0001; end
          default: begin d = $urandom; c = 4'($urandom_range(0, 15)) & 4'b1110; end
        endcase
        v = ($urandom_range(0, 9) < 8);
        held_d = d; held_c = c;
      end else v = 1'b1;
      step(v, held_d, held_c, ($urandom_range(0, 3) != 0), acc);
      pend = v && !acc;
    end
    idle(4);
    chk(q.size() == 0, "R7 all accepted dwords delivered", q.size(), 0);
    chk(obs_pulses == exp_pulses, "R6 total pulse count", obs_pulses, exp_pulses);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule